// File: doc/BRIEF.md
# Host-side System Memory Address Router

The router sits on the host side of a memory controller hub. Each request arrives with the following inputs:

- a 32-bit address
- a read/write flag
- the port it came from: processor, graphics port or I/O hub link
- an SMM-mode flag
- a write-back flag

The router classifies the address against the system memory map and sends the request to one of three places. It can serve the request from DRAM, pass it on to the hub link, or end it at once. For DRAM targets it also produces the DRAM address, which may differ from the request address.

Several configuration inputs shape the map and must be held steady while traffic flows:

- a top-of-memory value, which the router clamps to 512 MB
- an enable that opens a hole at 15–16 MB
- separate read and write shadow enables for the 64 KB BIOS segment
- an enable for a 128 KB high SMM segment at FEEA0000h

The result is registered, so a request presented in one cycle shows up on the outputs in the next cycle.

Top module: `mem_addr_router`

## Requirements
- R1: While rst_ni is low, rsp_valid_o is 0, rsp_target_o is 2'b00 and rsp_addr_o is 0.
- R2: A request sampled with req_valid_i high at a rising edge appears on the outputs after that edge, so the latency is one cycle. Back-to-back requests are each reported one cycle later. After an edge where req_valid_i was low, rsp_valid_o is 0, rsp_target_o is 2'b00 and rsp_addr_o is 0.
- R3: Addresses below F0000h go to DRAM (target 2'b00) at the same address, for reads and for writes.
- R4: A read in F0000h–FFFFFh goes to DRAM (2'b00) at the same address when cfg_bios_re_i is 1. Otherwise it goes to the hub link (2'b01) unchanged.
- R5: A write in F0000h–FFFFFh goes to DRAM (2'b00) at the same address when cfg_bios_we_i is 1. Otherwise it goes to the hub link (2'b01) unchanged. The read enable has no say over writes, and the write enable has no say over reads.
- R6: The effective top of memory is the smaller of cfg_tom_i and 20000000h. Addresses from 100000h up to but not including that value go to DRAM (2'b00) unchanged. Addresses from that value upward go to the hub link (2'b01) unchanged.
- R7: With cfg_hole_en_i at 1, addresses F00000h–FFFFFFh go to the hub link (2'b01) unchanged, even below top of memory. The addresses just outside the hole still go to DRAM. With the enable at 0, the range follows R6.
- R8: With cfg_hseg_en_i at 1, a processor request (req_src_i 2'b00) in SMM mode to FEEA0000h–FEEBFFFFh goes to DRAM (2'b00). Its DRAM address is A0000h OR'd with address bits 16:0.
- R9: With cfg_hseg_en_i at 1, a processor request to the segment outside SMM mode is terminated: target 2'b10, address 0. If req_wb_i is 1, it is instead remapped as in R8.
- R10: With cfg_hseg_en_i at 1, any request to the segment whose req_src_i is not 2'b00 is terminated (2'b10, address 0), whatever the SMM and write-back flags say. The graphics port is 2'b01 and the hub link is 2'b10.
- R11: With cfg_hseg_en_i at 0, the segment range goes to the hub link (2'b01) unchanged. So do the interrupt-controller windows FEC00000h and FEE00000h and the top 2 MB below 4 GB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Request address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_src_i | input | 2 | Requester: 00 processor, 01 graphics, 10 hub link |
| req_smm_i | input | 1 | Processor is in SMM mode |
| req_wb_i | input | 1 | Request is a cache write-back |
| cfg_tom_i | input | 32 | Top of memory, byte address |
| cfg_hole_en_i | input | 1 | Open the 15–16 MB hole |
| cfg_bios_re_i | input | 1 | Serve BIOS-segment reads from DRAM |
| cfg_bios_we_i | input | 1 | Serve BIOS-segment writes to DRAM |
| cfg_hseg_en_i | input | 1 | Enable the high SMM segment |
| rsp_valid_o | output | 1 | Routed result valid |
| rsp_target_o | output | 2 | 00 DRAM, 01 hub link, 10 terminated |
| rsp_addr_o | output | 32 | DRAM address, pass-through address, or 0 on termination |

## Verification
The 15–16 MB hole and the plain DRAM range claim the same addresses whenever top of memory lies above 16 MB. Both therefore match in one decode, and priority alone decides the outcome. The bench sets top of memory to 64 MB and opens the hole. It then probes the hole's first and last byte together with the bytes just outside it, expecting the hub link inside and DRAM outside. The SMM segment and the default PCI-memory routing overlap in the same way. That overlap is judged by sending the same segment address with the enable on and with it off.

// File: rtl/mem_route_pkg.sv
package mem_route_pkg;

  typedef enum logic [1:0] {
    TGT_DRAM = 2'b00,
    TGT_HUB  = 2'b01,
    TGT_TERM = 2'b10
  } tgt_e;

  localparam logic [1:0] SRC_CPU = 2'b00;

  typedef struct packed {
    logic hseg;
    logic bios;
    logic hole;
    logic low;
    logic ext;
  } region_t;

endpackage

// File: rtl/addr_window.sv
// Aligned power-of-two window match
module addr_window #(
  parameter int unsigned          ADDR_W = 32,
  parameter int unsigned          OFF_W  = 16,
  parameter logic [ADDR_W-1:0]    BASE   = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] TAG_MASK = ~{{(ADDR_W-OFF_W){1'b0}}, {OFF_W{1'b1}}};

  assign hit_o = ((addr_i & TAG_MASK) == (BASE & TAG_MASK));
endmodule

// File: rtl/addr_region_match.sv
module addr_region_match
  import mem_route_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] TOM_MAX    = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE   = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] BIOS_BASE  = 32'h000F_0000,
  parameter int unsigned       BIOS_OFF_W = 16,
  parameter logic [ADDR_W-1:0] HOLE_BASE  = 32'h00F0_0000,
  parameter int unsigned       HOLE_OFF_W = 20,
  parameter logic [ADDR_W-1:0] HSEG_BASE  = 32'hFEEA_0000,
  parameter int unsigned       HSEG_OFF_W = 17
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] tom_i,
  output region_t           hit_o
);
  logic [ADDR_W-1:0] tom_eff;
  logic bios_hit, hole_hit, hseg_hit;

  assign tom_eff = (tom_i > TOM_MAX) ? TOM_MAX : tom_i;

  addr_window #(.ADDR_W(ADDR_W), .OFF_W(BIOS_OFF_W), .BASE(BIOS_BASE)) u_bios (
    .addr_i(addr_i), .hit_o(bios_hit));
  addr_window #(.ADDR_W(ADDR_W), .OFF_W(HOLE_OFF_W), .BASE(HOLE_BASE)) u_hole (
    .addr_i(addr_i), .hit_o(hole_hit));
  addr_window #(.ADDR_W(ADDR_W), .OFF_W(HSEG_OFF_W), .BASE(HSEG_BASE)) u_hseg (
    .addr_i(addr_i), .hit_o(hseg_hit));

  always_comb begin
    hit_o      = '0;
    hit_o.hseg = hseg_hit;
    hit_o.bios = bios_hit;
    hit_o.hole = hole_hit;
    hit_o.low  = (addr_i < BIOS_BASE);
    hit_o.ext  = (addr_i >= EXT_BASE) && (addr_i < tom_eff);
  end
endmodule

// File: rtl/route_pick.sv
module route_pick
  import mem_route_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       HSEG_OFF_W = 17,
  parameter logic [ADDR_W-1:0] SMM_DST    = 32'h000A_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  region_t           hit_i,
  input  logic              write_i,
  input  logic [1:0]        src_i,
  input  logic              smm_i,
  input  logic              wb_i,
  input  logic              hole_en_i,
  input  logic              bios_re_i,
  input  logic              bios_we_i,
  input  logic              hseg_en_i,
  output tgt_e              tgt_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] OFF_MASK = {{(ADDR_W-HSEG_OFF_W){1'b0}}, {HSEG_OFF_W{1'b1}}};

  logic cpu_ok;
  assign cpu_ok = (src_i == SRC_CPU) && (smm_i || wb_i);

  // priority: smm seg > bios > hole > dram ranges > hub default
  always_comb begin
    tgt_o  = TGT_HUB;
    addr_o = addr_i;
    if (hit_i.hseg && hseg_en_i) begin
      if (cpu_ok) begin
        tgt_o  = TGT_DRAM;
        addr_o = SMM_DST | (addr_i & OFF_MASK);
      end else begin
        tgt_o  = TGT_TERM;
        addr_o = '0;
      end
    end else if (hit_i.bios) begin
      if (write_i ? bios_we_i : bios_re_i) tgt_o = TGT_DRAM;
    end else if (hit_i.hole && hole_en_i) begin
      tgt_o = TGT_HUB;
    end else if (hit_i.low || hit_i.ext) begin
      tgt_o = TGT_DRAM;
    end
  end
endmodule

// File: rtl/route_reg.sv
module route_reg
  import mem_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  tgt_e              tgt_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              vld_o,
  output logic [1:0]        tgt_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      tgt_o  <= 2'b00;
      addr_o <= '0;
    end else if (vld_i) begin
      vld_o  <= 1'b1;
      tgt_o  <= tgt_i;
      addr_o <= addr_i;
    end else begin
      vld_o  <= 1'b0;
      tgt_o  <= 2'b00;
      addr_o <= '0;
    end
  end
endmodule

// File: rtl/mem_addr_router.sv
module mem_addr_router
  import mem_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_src_i,
  input  logic              req_smm_i,
  input  logic              req_wb_i,
  input  logic [ADDR_W-1:0] cfg_tom_i,
  input  logic              cfg_hole_en_i,
  input  logic              cfg_bios_re_i,
  input  logic              cfg_bios_we_i,
  input  logic              cfg_hseg_en_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_target_o,
  output logic [ADDR_W-1:0] rsp_addr_o
);
  localparam int unsigned HSEG_OFF_W = 17;

  region_t           hit;
  tgt_e              tgt_d;
  logic [ADDR_W-1:0] addr_d;

  addr_region_match #(.ADDR_W(ADDR_W), .HSEG_OFF_W(HSEG_OFF_W)) u_match (
    .addr_i (req_addr_i),
    .tom_i  (cfg_tom_i),
    .hit_o  (hit)
  );

  route_pick #(.ADDR_W(ADDR_W), .HSEG_OFF_W(HSEG_OFF_W)) u_pick (
    .addr_i    (req_addr_i),
    .hit_i     (hit),
    .write_i   (req_write_i),
    .src_i     (req_src_i),
    .smm_i     (req_smm_i),
    .wb_i      (req_wb_i),
    .hole_en_i (cfg_hole_en_i),
    .bios_re_i (cfg_bios_re_i),
    .bios_we_i (cfg_bios_we_i),
    .hseg_en_i (cfg_hseg_en_i),
    .tgt_o     (tgt_d),
    .addr_o    (addr_d)
  );

  route_reg #(.ADDR_W(ADDR_W)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (req_valid_i),
    .tgt_i  (tgt_d),
    .addr_i (addr_d),
    .vld_o  (rsp_valid_o),
    .tgt_o  (rsp_target_o),
    .addr_o (rsp_addr_o)
  );
endmodule

// File: rtl/mem_addr_router_chk.sv
module mem_addr_router_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] req_addr_i,
  input logic [1:0]  req_src_i,
  input logic        req_smm_i,
  input logic        req_wb_i,
  input logic        cfg_hole_en_i,
  input logic        cfg_hseg_en_i,
  input logic        rsp_valid_o,
  input logic [1:0]  rsp_target_o,
  input logic [31:0] rsp_addr_o
);
  logic in_seg, in_hole;
  assign in_seg  = (req_addr_i[31:17] == 15'h7F75);
  assign in_hole = (req_addr_i[31:20] == 12'h00F);

  assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && rsp_target_o == 2'b00 && rsp_addr_o == 32'h0));

  assert_low_dram_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i < 32'h000F_0000)
    |=> (rsp_target_o == 2'b00 && rsp_addr_o == $past(req_addr_i)));

  assert_hole_hub_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_hole_en_i && in_hole)
    |=> (rsp_target_o == 2'b01 && rsp_addr_o == $past(req_addr_i)));

  assert_smm_remap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_hseg_en_i && in_seg && req_src_i == 2'b00 && req_smm_i)
    |=> (rsp_target_o == 2'b00 &&
         rsp_addr_o == (32'h000A_0000 | {15'h0, $past(req_addr_i[16:0])})));

  assert_term_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_hseg_en_i && in_seg && req_src_i == 2'b00 && !req_smm_i && !req_wb_i)
    |=> (rsp_target_o == 2'b10 && rsp_addr_o == 32'h0));

  assert_foreign_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_hseg_en_i && in_seg && req_src_i != 2'b00)
    |=> (rsp_target_o == 2'b10));

  assert_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_target_o != 2'b11));
endmodule

bind mem_addr_router mem_addr_router_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_addr_i    (req_addr_i),
  .req_src_i     (req_src_i),
  .req_smm_i     (req_smm_i),
  .req_wb_i      (req_wb_i),
  .cfg_hole_en_i (cfg_hole_en_i),
  .cfg_hseg_en_i (cfg_hseg_en_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_target_o  (rsp_target_o),
  .rsp_addr_o    (rsp_addr_o)
);

// File: tb/mem_addr_router_test.sv
module mem_addr_router_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] DR = 2'b00, HB = 2'b01, TM = 2'b10;
  localparam logic [1:0] CPU = 2'b00, GFX = 2'b01, HUBL = 2'b10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_write_i = 1'b0;
  logic [1:0]  req_src_i = CPU;
  logic        req_smm_i = 1'b0;
  logic        req_wb_i = 1'b0;
  logic [31:0] cfg_tom_i = 32'h0400_0000;
  logic        cfg_hole_en_i = 1'b0;
  logic        cfg_bios_re_i = 1'b0;
  logic        cfg_bios_we_i = 1'b0;
  logic        cfg_hseg_en_i = 1'b0;
  logic        rsp_valid_o;
  logic [1:0]  rsp_target_o;
  logic [31:0] rsp_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mem_addr_router uut (.*);

  task automatic judge(input logic v, input logic [1:0] t, input logic [31:0] a,
                       input logic [1:0] et, input logic [31:0] ea, input string tag);
    total++;
    if (v !== 1'b1 || t !== et || a !== ea) begin
      bad++;
      $display("FAIL %s: valid=%b target=%b addr=%h expected valid=1 target=%b addr=%h",
               tag, v, t, a, et, ea);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic wr, input logic [1:0] src,
                      input logic smm, input logic wb,
                      input logic [1:0] et, input logic [31:0] ea, input string tag);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_write_i = wr;
    req_src_i = src; req_smm_i = smm; req_wb_i = wb;
    @(negedge clk_i);
    judge(rsp_valid_o, rsp_target_o, rsp_addr_o, et, ea, tag);
    req_valid_i = 1'b0;
  endtask

  task automatic t_reset_R1;
    repeat (2) @(negedge clk_i);
    total++;
    if (rsp_valid_o !== 1'b0 || rsp_target_o !== 2'b00 || rsp_addr_o !== 32'h0) begin
      bad++;
      $display("FAIL R1: valid=%b target=%b addr=%h expected 0/00/0",
               rsp_valid_o, rsp_target_o, rsp_addr_o);
    end
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_pipeline_R2;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = 32'h0000_4000; req_write_i = 1'b0; req_src_i = CPU;
    @(negedge clk_i);
    judge(rsp_valid_o, rsp_target_o, rsp_addr_o, DR, 32'h0000_4000, "R2 first");
    req_addr_i = 32'hFEC0_0040;
    @(negedge clk_i);
    judge(rsp_valid_o, rsp_target_o, rsp_addr_o, HB, 32'hFEC0_0040, "R2 second");
    req_valid_i = 1'b0;
    @(negedge clk_i);
    total++;
    if (rsp_valid_o !== 1'b0 || rsp_target_o !== 2'b00 || rsp_addr_o !== 32'h0) begin
      bad++;
      $display("FAIL R2 idle: valid=%b target=%b addr=%h expected 0/00/0",
               rsp_valid_o, rsp_target_o, rsp_addr_o);
    end
  endtask

  task automatic t_low_R3;
    send(32'h0000_1234, 1'b0, CPU, 1'b0, 1'b0, DR, 32'h0000_1234, "R3 read");
    send(32'h000E_FFFF, 1'b1, GFX, 1'b0, 1'b0, DR, 32'h000E_FFFF, "R3 write");
  endtask

  task automatic t_bios_R4_R5;
    cfg_bios_re_i = 1'b0; cfg_bios_we_i = 1'b1;
    send(32'h000F_1234, 1'b0, CPU, 1'b0, 1'b0, HB, 32'h000F_1234, "R4 read disabled");
    send(32'h000F_1234, 1'b1, CPU, 1'b0, 1'b0, DR, 32'h000F_1234, "R5 write enabled");
    cfg_bios_re_i = 1'b1; cfg_bios_we_i = 1'b0;
    send(32'h000F_FFFF, 1'b0, CPU, 1'b0, 1'b0, DR, 32'h000F_FFFF, "R4 read enabled");
    send(32'h000F_0000, 1'b1, CPU, 1'b0, 1'b0, HB, 32'h000F_0000, "R5 write disabled");
    cfg_bios_re_i = 1'b0;
  endtask

  task automatic t_tom_R6;
    cfg_tom_i = 32'h0400_0000;
    send(32'h0010_0000, 1'b0, CPU, 1'b0, 1'b0, DR, 32'h0010_0000, "R6 ext base");
    send(32'h03FF_FFFC, 1'b1, CPU, 1'b0, 1'b0, DR, 32'h03FF_FFFC, "R6 below tom");
    send(32'h0400_0000, 1'b0, CPU, 1'b0, 1'b0, HB, 32'h0400_0000, "R6 at tom");
    cfg_tom_i = 32'hFFFF_0000;
    send(32'h1FFF_FFFF, 1'b0, CPU, 1'b0, 1'b0, DR, 32'h1FFF_FFFF, "R6 clamp below");
    send(32'h2000_0000, 1'b0, CPU, 1'b0, 1'b0, HB, 32'h2000_0000, "R6 clamp at");
    cfg_tom_i = 32'h0400_0000;
  endtask

  task automatic t_hole_R7;
    send(32'h00F8_0000, 1'b0, CPU, 1'b0, 1'b0, DR, 32'h00F8_0000, "R7 hole closed");
    cfg_hole_en_i = 1'b1;
    send(32'h00F0_0000, 1'b0, CPU, 1'b0, 1'b0, HB, 32'h00F0_0000, "R7 hole first");
    send(32'h00FF_FFFF, 1'b1, CPU, 1'b0, 1'b0, HB, 32'h00FF_FFFF, "R7 hole last");
    send(32'h00EF_FFFF, 1'b0, CPU, 1'b0, 1'b0, DR, 32'h00EF_FFFF, "R7 below hole");
    send(32'h0100_0000, 1'b0, CPU, 1'b0, 1'b0, DR, 32'h0100_0000, "R7 above hole");
    cfg_hole_en_i = 1'b0;
  endtask

  task automatic t_smm_R8_R9_R10;
    cfg_hseg_en_i = 1'b1;
    send(32'hFEEA_1234, 1'b0, CPU, 1'b1, 1'b0, DR, 32'h000A_1234, "R8 smm low");
    send(32'hFEEB_FFFF, 1'b1, CPU, 1'b1, 1'b0, DR, 32'h000B_FFFF, "R8 smm high");
    send(32'hFEEA_0010, 1'b0, CPU, 1'b0, 1'b0, TM, 32'h0,        "R9 non-smm term");
    send(32'hFEEA_0010, 1'b1, CPU, 1'b0, 1'b1, DR, 32'h000A_0010, "R9 writeback remap");
    send(32'hFEEB_0000, 1'b0, GFX, 1'b1, 1'b0, TM, 32'h0,        "R10 graphics");
    send(32'hFEEB_0000, 1'b1, HUBL, 1'b0, 1'b1, TM, 32'h0,       "R10 hub wb");
    send(32'hFEEA_0000, 1'b0, 2'b11, 1'b1, 1'b1, TM, 32'h0,      "R10 code 11");
    cfg_hseg_en_i = 1'b0;
  endtask

  task automatic t_pci_R11;
    send(32'hFEEA_1234, 1'b0, CPU, 1'b1, 1'b0, HB, 32'hFEEA_1234, "R11 seg off");
    send(32'hFEE0_0000, 1'b1, CPU, 1'b0, 1'b0, HB, 32'hFEE0_0000, "R11 irq window");
    send(32'hFFE0_0000, 1'b0, CPU, 1'b0, 1'b0, HB, 32'hFFE0_0000, "R11 high bios");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_R1();
    t_pipeline_R2();
    t_low_R3();
    t_bios_R4_R5();
    t_tom_R6();
    t_hole_R7();
    t_smm_R8_R9_R10();
    t_pci_R11();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule